// File: doc/BRIEF.md
# AXI4 Memory Slave with Selectable Commit Timing

This block is an AXI4 slave backed by a small word-addressed memory. It accepts one write burst (address, data and response channels) and one read burst (address and data channels) at a time. The two directions run independently. Bursts are incrementing, use the full data width, and carry up to 16 beats. Every response is OKAY.

The block has two run-time mode pins. The commit mode decides how the memory is touched. In burst mode, writes are gathered into a burst buffer and stored to memory together after the final beat, and reads take a snapshot of the whole burst before the first beat is sent. In beat mode, each accepted write beat goes straight to memory, and each read word is fetched just before that beat is driven. The commit mode is sampled when a burst's address is accepted and holds for that whole burst.

The ready-timing mode decides when the programmable wait on each of the three ready outputs starts counting. It counts either from the cycle the matching valid rises, or from the last handshake on that channel. In the second case a ready can be raised before its valid.

Top module: `axi_commit_slave`

## Requirements
- R1: After reset, bvalid and rvalid are low and every memory word reads as zero.
- R2: With commit mode 0 (burst), a write burst leaves the memory unchanged until its WLAST beat is accepted. All of its words are then stored together before bvalid rises. A read issued while such a write is still open returns the old contents.
- R3: With commit mode 0, a read burst copies all of its words out of memory before its first beat is driven. A write that lands after that copy does not change the beats still to be sent. The mode is taken at address acceptance, so changing the mode pin in mid-burst has no effect.
- R4: With commit mode 1 (beat), each write beat is in memory from the clock edge that accepts it, before the rest of the burst arrives.
- R5: With commit mode 1, each read beat's word is fetched only after the previous beat is accepted, so it reflects writes made while the earlier beat was waiting.
- R6: A read burst returns arlen+1 beats. RLAST is high on the last beat only, RRESP is 2'b00, and rvalid with its data holds until rready.
- R7: bvalid rises only after the WLAST beat is accepted, holds until bready, and BRESP is 2'b00.
- R8: With ready mode 0, AWREADY, WREADY and ARREADY each stay low for exactly the programmed number of cycles (0 to 15) while their valid is high. They are never high while their valid is low.
- R9: With ready mode 1, each wait counts from the previous handshake on that channel. A transfer presented g cycles after that handshake waits max(0, delay - g) cycles, and a ready may be high while its valid is low.
- R10: Beat i of a burst at byte address A uses word ((A/4)+i) modulo the memory depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | Commit mode: 0 burst, 1 beat |
| rdy_mode | input | 1 | Ready wait origin: 0 from valid, 1 from previous handshake |
| aw_dly | input | DLY_W | AWREADY wait cycles |
| w_dly | input | DLY_W | WREADY wait cycles |
| ar_dly | input | DLY_W | ARREADY wait cycles |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| awlen | input | 8 | Write beats minus one |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| arlen | input | 8 | Read beats minus one |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |

## Verification
The bench overlaps the two directions on purpose. In burst mode it reads in the middle of an open write, and a design that stores beats early returns new data there. It writes while a burst read is stalled, so a design without a snapshot leaks the new word into a later beat. In beat mode it writes while a read beat is stalled, and a design that prefetches returns the stale word. Ready waits are measured in cycles under both origin modes, with idle gaps between beats. A counter with the wrong origin, or one that misses saturation, gives the wrong wait count or no early ready. A write wrapping past the top word and a 16-beat read cover addressing and RLAST placement.

// File: rtl/axi_commit_slave.sv
module axi_commit_slave #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int MAX_BEATS = 16,
  parameter int DLY_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              rdy_mode,
  input  logic [DLY_W-1:0]  aw_dly,
  input  logic [DLY_W-1:0]  w_dly,
  input  logic [DLY_W-1:0]  ar_dly,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);
  localparam int IDX_W  = $clog2(MEM_WORDS);
  localparam int BEAT_W = $clog2(MAX_BEATS);
  localparam int LSB    = $clog2(DATA_W / 8);

  typedef enum logic [1:0] {W_ADDR, W_DATA, W_COMMIT, W_RESP} wst_e;
  typedef enum logic [1:0] {R_ADDR, R_FILL, R_FETCH, R_DATA} rst_e;

  wst_e w_st;
  rst_e r_st;
  logic              w_mode, r_mode;
  logic [IDX_W-1:0]  w_base, r_base;
  logic [BEAT_W-1:0] w_len, w_beat, r_len, r_beat;
  logic [DATA_W-1:0] mem  [MEM_WORDS];
  logic [DATA_W-1:0] wbuf [MAX_BEATS];
  logic [DATA_W-1:0] rbuf [MAX_BEATS];
  logic [DATA_W-1:0] rdata_q;

  function automatic logic [IDX_W-1:0] widx(input logic [IDX_W-1:0] b, input logic [BEAT_W-1:0] o);
    return b + IDX_W'(o);
  endfunction

  logic [2:0]       vld, arm, rdy, hs;
  logic [DLY_W-1:0] dly [3];
  logic [DLY_W-1:0] cnt [3];

  assign vld    = {arvalid, wvalid, awvalid};
  assign arm    = {r_st == R_ADDR, w_st == W_DATA, w_st == W_ADDR};
  assign dly[0] = aw_dly;
  assign dly[1] = w_dly;
  assign dly[2] = ar_dly;
  assign hs     = vld & rdy;

  for (genvar c = 0; c < 3; c++) begin : g_dly
    assign rdy[c] = arm[c] && (rdy_mode || vld[c]) && (cnt[c] >= dly[c]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt[c] <= '0;
      else if (hs[c] || (!rdy_mode && !vld[c])) cnt[c] <= '0;
      else if (cnt[c] != '1)                  cnt[c] <= cnt[c] + 1'b1;
    end
  end

  assign awready = rdy[0];
  assign wready  = rdy[1];
  assign arready = rdy[2];
  assign bvalid  = (w_st == W_RESP);
  assign bresp   = 2'b00;
  assign rvalid  = (r_st == R_DATA);
  assign rdata   = rdata_q;
  assign rlast   = rvalid && (r_beat == r_len);
  assign rresp   = 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_st <= W_ADDR; w_mode <= 1'b0; w_base <= '0; w_len <= '0; w_beat <= '0;
    end else begin
      case (w_st)
        W_ADDR: if (hs[0]) begin
          w_base <= awaddr[LSB +: IDX_W];
          w_len  <= awlen[BEAT_W-1:0];
          w_beat <= '0;
          w_mode <= slave_mode;
          w_st   <= W_DATA;
        end
        W_DATA: if (hs[1]) begin
          w_beat <= w_beat + 1'b1;
          if (wlast) w_st <= w_mode ? W_RESP : W_COMMIT;
        end
        W_COMMIT: w_st <= W_RESP;
        W_RESP:   if (bready) w_st <= W_ADDR;
        default:  w_st <= W_ADDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_st <= R_ADDR; r_mode <= 1'b0; r_base <= '0; r_len <= '0; r_beat <= '0; rdata_q <= '0;
    end else begin
      case (r_st)
        R_ADDR: if (hs[2]) begin
          r_base <= araddr[LSB +: IDX_W];
          r_len  <= arlen[BEAT_W-1:0];
          r_beat <= '0;
          r_mode <= slave_mode;
          r_st   <= slave_mode ? R_FETCH : R_FILL;
        end
        R_FILL:  r_st <= R_FETCH;
        R_FETCH: begin
          rdata_q <= r_mode ? mem[widx(r_base, r_beat)] : rbuf[r_beat];
          r_st    <= R_DATA;
        end
        R_DATA: if (rready) begin
          if (r_beat == r_len) r_st <= R_ADDR;
          else begin
            r_beat <= r_beat + 1'b1;
            r_st   <= R_FETCH;
          end
        end
        default: r_st <= R_ADDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (w_st == W_DATA && hs[1]) wbuf[w_beat] <= wdata;
    if (r_st == R_FILL)
      for (int k = 0; k < MAX_BEATS; k++) rbuf[k] <= mem[widx(r_base, BEAT_W'(k))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (w_st == W_DATA && hs[1] && w_mode) begin
      mem[widx(w_base, w_beat)] <= wdata;
    end else if (w_st == W_COMMIT) begin
      for (int k = 0; k < MAX_BEATS; k++)
        if (BEAT_W'(k) <= w_len) mem[widx(w_base, BEAT_W'(k))] <= wbuf[k];
    end
  end
endmodule

// File: rtl/axi_commit_slave_chk.sv
module axi_commit_slave_chk #(
  parameter int DATA_W = 32,
  parameter int DLY_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_mode,
  input logic [DLY_W-1:0]  aw_dly,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bvalid,
  input logic              bready,
  input logic              arvalid,
  input logic              arready,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready,
  input logic              rlast,
  input logic [DATA_W-1:0] rdata
);
  logic [DLY_W-1:0] aw_wait;
  logic             seen_last;
  logic [7:0]       r_cnt, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_wait <= '0; seen_last <= 1'b0; r_cnt <= '0; len_q <= '0;
    end else begin
      if (!awvalid || awready) aw_wait <= '0;
      else if (aw_wait != '1)  aw_wait <= aw_wait + 1'b1;
      if (wvalid && wready && wlast) seen_last <= 1'b1;
      else if (bvalid && bready)     seen_last <= 1'b0;
      if (arvalid && arready) begin
        len_q <= arlen; r_cnt <= '0;
      end else if (rvalid && rready) r_cnt <= r_cnt + 1'b1;
    end
  end

  AST_AW_WAIT_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready && !rdy_mode) |-> (aw_wait >= aw_dly)); // R8
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_mode |-> ((!awready || awvalid) && (!wready || wvalid) && (!arready || arvalid))); // R8
  AST_B_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> seen_last); // R7
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid); // R7
  AST_RLAST_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rlast == (r_cnt == len_q))); // R6
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast))); // R6
endmodule

bind axi_commit_slave axi_commit_slave_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_mode(rdy_mode), .aw_dly(aw_dly),
  .awvalid(awvalid), .awready(awready), .wvalid(wvalid), .wready(wready), .wlast(wlast),
  .bvalid(bvalid), .bready(bready), .arvalid(arvalid), .arready(arready), .arlen(arlen),
  .rvalid(rvalid), .rready(rready), .rlast(rlast), .rdata(rdata)
);

// File: tb/test_axi_commit_slave.sv
`timescale 1ns/1ps
module test_axi_commit_slave;
  logic clk = 0, rst_n = 0;
  logic slave_mode = 0, rdy_mode = 0;
  logic [3:0] aw_dly = 0, w_dly = 0, ar_dly = 0;
  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 0, arvalid = 0, rready = 0;
  logic awready, wready, bvalid, arready, rvalid, rlast;
  logic [11:0] awaddr = 0, araddr = 0;
  logic [7:0]  awlen = 0, arlen = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  bresp, rresp;
  logic [31:0] mdl [64];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  axi_commit_slave i_axi_commit_slave (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .rdy_mode(rdy_mode),
    .aw_dly(aw_dly), .w_dly(w_dly), .ar_dly(ar_dly),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast));

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic aw_send(input int wa, input int len, output int waits);
    @(negedge clk); awvalid = 1; awaddr = 12'(wa * 4); awlen = 8'(len); waits = 0;
    #1; while (!awready) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1 awvalid = 0;
  endtask

  task automatic ar_send(input int wa, input int len, output int waits);
    @(negedge clk); arvalid = 1; araddr = 12'(wa * 4); arlen = 8'(len); waits = 0;
    #1; while (!arready) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1 arvalid = 0;
  endtask

  task automatic w_send(input logic [31:0] d, input bit last, input int gap, output int waits);
    @(negedge clk);
    repeat (gap) @(negedge clk);
    wvalid = 1; wdata = d; wlast = last; waits = 0;
    #1; while (!wready) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1 wvalid = 0; wlast = 0;
  endtask

  task automatic b_take(input string req);
    @(negedge clk); bready = 1;
    #1; while (!bvalid) begin @(negedge clk); #1; end
    chk(bresp == 2'b00, req, "bresp", 32'(bresp), 0);
    @(posedge clk); #1 bready = 0;
  endtask

  task automatic wait_rvalid();
    @(negedge clk); #1; while (!rvalid) begin @(negedge clk); #1; end
  endtask

  task automatic r_take(output logic [31:0] d, output logic l, output logic [1:0] rs);
    @(negedge clk); rready = 1;
    #1; while (!rvalid) begin @(negedge clk); #1; end
    d = rdata; l = rlast; rs = rresp;
    @(posedge clk); #1 rready = 0;
  endtask

  task automatic rd_check(input int wa, input int n, input string req);
    int w; logic [31:0] d; logic l; logic [1:0] rs;
    ar_send(wa, n - 1, w);
    for (int i = 0; i < n; i++) begin
      r_take(d, l, rs);
      chk(d == mdl[(wa + i) % 64], req, $sformatf("rdata word %0d", (wa + i) % 64), d, mdl[(wa + i) % 64]);
      chk(l == (i == n - 1), "R6", "rlast", 32'(l), 32'(i == n - 1));
      chk(rs == 2'b00, "R6", "rresp", 32'(rs), 0);
    end
  endtask

  task automatic t_reset();
    chk(bvalid == 0, "R1", "bvalid after reset", 32'(bvalid), 0);
    chk(rvalid == 0, "R1", "rvalid after reset", 32'(rvalid), 0);
    rd_check(0, 4, "R1");
  endtask

  task automatic t_burst_write();
    int w;
    slave_mode = 0;
    aw_send(8, 3, w);
    for (int i = 0; i < 3; i++) w_send(32'hA000_0000 + 32'(i), 0, 0, w);
    repeat (3) @(negedge clk);
    chk(bvalid == 0, "R7", "bvalid before wlast", 32'(bvalid), 0);
    rd_check(8, 4, "R2");
    w_send(32'hA000_0003, 1, 0, w);
    for (int i = 0; i < 4; i++) mdl[8 + i] = 32'hA000_0000 + 32'(i);
    b_take("R7");
    rd_check(8, 4, "R2");
  endtask

  task automatic t_burst_read_snapshot();
    int w; logic [31:0] d; logic l; logic [1:0] rs; logic [31:0] old8, old9;
    slave_mode = 0;
    old8 = mdl[8]; old9 = mdl[9];
    ar_send(8, 1, w);
    wait_rvalid();
    slave_mode = 1;
    aw_send(9, 0, w);
    w_send(32'hB0B0_0009, 1, 0, w);
    b_take("R7");
    mdl[9] = 32'hB0B0_0009;
    r_take(d, l, rs);
    chk(d == old8, "R3", "snapshot beat0", d, old8);
    r_take(d, l, rs);
    chk(d == old9, "R3", "snapshot beat1 ignores later write", d, old9);
    chk(l == 1, "R6", "rlast", 32'(l), 1);
    slave_mode = 0;
    rd_check(9, 1, "R3");
  endtask

  task automatic t_beat_write();
    int w;
    slave_mode = 1;
    aw_send(20, 2, w);
    w_send(32'hC000_0020, 0, 0, w);
    mdl[20] = 32'hC000_0020;
    rd_check(20, 2, "R4");
    w_send(32'hC000_0021, 0, 0, w);
    w_send(32'hC000_0022, 1, 0, w);
    mdl[21] = 32'hC000_0021; mdl[22] = 32'hC000_0022;
    b_take("R7");
    rd_check(20, 3, "R4");
  endtask

  task automatic t_beat_read();
    int w; logic [31:0] d; logic l; logic [1:0] rs;
    slave_mode = 1;
    aw_send(30, 1, w);
    w_send(32'hD000_0030, 0, 0, w);
    mdl[30] = 32'hD000_0030;
    ar_send(30, 1, w);
    wait_rvalid();
    w_send(32'hD000_0031, 1, 0, w);
    mdl[31] = 32'hD000_0031;
    r_take(d, l, rs);
    chk(d == mdl[30], "R5", "beat0", d, mdl[30]);
    r_take(d, l, rs);
    chk(d == mdl[31], "R5", "beat1 fetched late", d, mdl[31]);
    b_take("R7");
  endtask

  task automatic t_long_and_wrap();
    int w;
    slave_mode = 0;
    aw_send(63, 1, w);
    w_send(32'hE000_003F, 0, 0, w);
    w_send(32'hE000_0000, 1, 0, w);
    mdl[63] = 32'hE000_003F; mdl[0] = 32'hE000_0000;
    b_take("R7");
    rd_check(63, 2, "R10");
    rd_check(0, 16, "R6");
  endtask

  task automatic t_delay_valid();
    int w;
    rdy_mode = 0; aw_dly = 3; w_dly = 2; ar_dly = 5; slave_mode = 1;
    @(negedge clk);
    aw_send(40, 1, w);
    chk(w == 3, "R8", "awready wait", 32'(w), 3);
    w_send(32'h1, 0, 0, w);
    chk(w == 2, "R8", "wready wait beat0", 32'(w), 2);
    w_send(32'h2, 1, 2, w);
    chk(w == 2, "R8", "wready wait after gap", 32'(w), 2);
    mdl[40] = 32'h1; mdl[41] = 32'h2;
    b_take("R7");
    ar_send(40, 0, w);
    chk(w == 5, "R8", "arready wait", 32'(w), 5);
    begin
      logic [31:0] d; logic l; logic [1:0] rs;
      r_take(d, l, rs);
      chk(d == 32'h1, "R8", "read after delays", d, 32'h1);
    end
  endtask

  task automatic t_delay_prev();
    int w;
    rdy_mode = 1; aw_dly = 5; w_dly = 3; ar_dly = 4;
    repeat (20) @(negedge clk);
    #1;
    chk(awready == 1 && awvalid == 0, "R9", "awready before awvalid", 32'(awready), 1);
    chk(arready == 1 && arvalid == 0, "R9", "arready before arvalid", 32'(arready), 1);
    aw_send(44, 2, w);
    chk(w == 0, "R9", "aw wait after idle", 32'(w), 0);
    w_send(32'h11, 0, 0, w);
    chk(w == 0, "R9", "w wait beat0", 32'(w), 0);
    w_send(32'h12, 0, 0, w);
    chk(w == 3, "R9", "w wait back to back", 32'(w), 3);
    w_send(32'h13, 1, 2, w);
    chk(w == 1, "R9", "w wait with gap 2", 32'(w), 1);
    mdl[44] = 32'h11; mdl[45] = 32'h12; mdl[46] = 32'h13;
    b_take("R7");
    rdy_mode = 0; aw_dly = 0; w_dly = 0; ar_dly = 0;
    rd_check(44, 3, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_burst_write();
    t_burst_read_snapshot();
    t_beat_write();
    t_beat_read();
    t_long_and_wrap();
    t_delay_valid();
    t_delay_prev();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule